// File: doc/BRIEF.md
# Display-List Video Timing Coprocessor

This block is a small real-time engine that steps through a display list held in memory. It reads the list one byte at a time through a dedicated DMA channel and turns each pair of bytes into a 16-bit move-style instruction. There are only two operations. One loads an immediate byte into a video control register. The other copies one control register into another. The registers it drives hold the sync control, the four bitplane pointers (two bytes each) and a 16-entry colour palette. Every register write, whether it comes from the list or from the CPU, is presented on a registered write bus, and the video pipeline downstream listens to that bus.

The block runs on the dot clock, so one clock equals one pixel. The CPU loads a list start pointer. When the beam reaches column 0 of the configured reload line, the coprocessor restarts at that pointer and executes the list until it meets a stop instruction. A fetch takes two pixel times, so with the DMA grant held high each instruction's effect lands exactly two pixels after the one before it. The CPU may write any control register directly. A CPU write always takes the bus in its own cycle, and a list write that was due in that cycle waits one cycle.

The register map uses byte addresses. Address 0 holds sync control. Addresses 8 to 15 hold the bitplane pointers, with the low byte at the even address. Addresses 16 to 31 hold the palette. Addresses from NREG up to 126 are unmapped.

Top module: `dlist_copro`

## Requirements
- R1: After synchronous reset, and until the first reload, `dma_req` and `reg_wr_en` are both low.
- R2: A reload occurs on a clock edge where `h_pos` is 0 and `v_pos` equals V_RELOAD. In the cycle after that edge, `dma_req` is high and `dma_addr` equals the start pointer. An instruction's low byte is at the lower address and its high byte at the next address.
- R3: A word with bit 15 = 1 loads the byte in bits 7:0 into the register addressed by bits 14:8.
- R4: A word with bit 15 = 0 copies the register addressed by bits 13:7 into the register addressed by bits 6:0. The value copied is the current one, so it includes earlier writes from the list, and bit 14 is ignored.
- R5: With the grant held high, the write of list instruction k appears on the bus 2k+3 cycles after the reload edge. Successive list writes are therefore exactly two pixels apart.
- R6: When the grant is withheld, fetching stalls. A low byte that has already been taken is kept, no byte is lost or repeated, and the same write sequence results.
- R7: A CPU write to a mapped address appears on the bus in the next cycle. If a list write was due in that cycle, it appears one cycle later, and the rest of the list shifts by one cycle.
- R8: An instruction whose destination is 127 performs no write, and `dma_req` then stays low until the next reload.
- R9: Writes to destinations from NREG up to 126, whether from the list or from the CPU, produce no bus write. A copy from such a source delivers 0.
- R10: A new start pointer takes effect only at the next reload. A reload in the middle of an instruction discards that partly fetched instruction.
- R11: `dma_addr` advances by exactly one for every accepted byte, and a byte is accepted on an edge where both `dma_req` and `dma_gnt` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock, one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | output | 1 | List fetch request |
| dma_addr | output | AW | Byte address of the requested list byte |
| dma_gnt | input | 1 | Grant; the byte on `dma_data` is taken on an edge where request and grant are both high |
| dma_data | input | 8 | List byte returned for `dma_addr` |
| cpu_ptr_we | input | 1 | CPU strobe to load the start pointer |
| cpu_ptr | input | AW | New list start pointer |
| cpu_we | input | 1 | CPU direct register write strobe |
| cpu_addr | input | 7 | CPU register address |
| cpu_data | input | 8 | CPU register data |
| h_pos | input | HW | Beam column |
| v_pos | input | VW | Beam line |
| reg_wr_en | output | 1 | Register write valid |
| reg_wr_addr | output | 7 | Register written |
| reg_wr_data | output | 8 | Value written |

## Verification
Two pairs of events can fall on the same edge. The first pair is a CPU register write and a list write that is ready to retire. The second pair is a reload and the arrival of an instruction's high byte. For the first pair, the bench places a CPU write exactly on the edge where a list load would retire. It then requires the CPU value on the bus at that edge, the postponed list write one cycle later, and every following list write one cycle late. For the second pair, the bench fires a reload on the edge where the high byte of the second instruction would arrive. It requires that this instruction never appears, and that the new list's first write lands three cycles after the new reload edge.

// File: rtl/dlc_pkg.sv
`timescale 1ns/1ps
package dlc_pkg;
  localparam int RA_W = 7;
  localparam logic [RA_W-1:0] STOP_DST = '1;

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fstate_t;

  typedef struct packed {
    logic            is_ld;
    logic [RA_W-1:0] src;
    logic [RA_W-1:0] dst;
    logic [7:0]      imm;
  } dec_t;

  function automatic dec_t decode(input logic [15:0] w);
    dec_t d;
    d.is_ld = w[15];
    d.src   = w[13:7];
    d.dst   = w[15] ? w[14:8] : w[6:0];
    d.imm   = w[7:0];
    return d;
  endfunction

  function automatic logic is_stop(input logic [15:0] w);
    return w[15] ? (w[14:8] == STOP_DST) : (w[6:0] == STOP_DST);
  endfunction
endpackage

// File: rtl/dlc_fetch.sv
`timescale 1ns/1ps
module dlc_fetch
  import dlc_pkg::*;
#(
  parameter int AW       = 16,
  parameter int HW       = 10,
  parameter int VW       = 10,
  parameter int V_RELOAD = 480
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_pos,
  input  logic [VW-1:0] v_pos,
  input  logic          ptr_we,
  input  logic [AW-1:0] ptr_in,
  output logic          dma_req,
  output logic [AW-1:0] dma_addr,
  input  logic          dma_gnt,
  input  logic [7:0]    dma_data,
  output logic          pend_vld,
  output logic [15:0]   pend_word,
  input  logic          take
);
  localparam logic [VW-1:0] RELOAD_LINE = VW'(V_RELOAD);

  fstate_t       st_q;
  logic [AW-1:0] start_q;
  logic [AW-1:0] ip_q;
  logic [7:0]    lo_q;
  logic          pend_q;
  logic [15:0]   word_q;

  logic        frame_go;
  logic        accept;
  logic [15:0] hi_word;

  assign frame_go = (h_pos == '0) && (v_pos == RELOAD_LINE);
  // high byte waits while the previous word has not retired
  assign dma_req  = (st_q == F_LO) || ((st_q == F_HI) && !pend_q);
  assign dma_addr = ip_q;
  assign accept   = dma_req && dma_gnt;
  assign hi_word  = {dma_data, lo_q};

  assign pend_vld  = pend_q;
  assign pend_word = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= F_IDLE;
      start_q <= '0;
      ip_q    <= '0;
      lo_q    <= '0;
      pend_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      if (ptr_we) start_q <= ptr_in;
      if (frame_go) begin
        ip_q   <= start_q;
        st_q   <= F_LO;
        pend_q <= 1'b0;
      end else begin
        if (take) pend_q <= 1'b0;
        if (accept) begin
          ip_q <= ip_q + AW'(1);
          if (st_q == F_LO) begin
            lo_q <= dma_data;
            st_q <= F_HI;
          end else if (is_stop(hi_word)) begin
            st_q <= F_IDLE;
          end else begin
            word_q <= hi_word;
            pend_q <= 1'b1;
            st_q   <= F_LO;
          end
        end
      end
    end
  end

  AST_RELOAD_PTR: assert property (@(posedge clk) disable iff (rst)
    frame_go |=> (dma_req && dma_addr == $past(start_q)));                 // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (accept && !frame_go) |=> (dma_addr == $past(dma_addr) + AW'(1)));      // R11
  AST_HOLD_LO: assert property (@(posedge clk) disable iff (rst)
    (st_q == F_HI && !accept && !frame_go) |=> (st_q == F_HI && $stable(lo_q))); // R6
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !take && !frame_go) |=> (pend_q && $stable(word_q)));        // R7
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (accept && st_q == F_HI && dma_data == 8'hFF && !frame_go) |=> !dma_req); // R8
endmodule

// File: rtl/dlc_exec.sv
`timescale 1ns/1ps
module dlc_exec
  import dlc_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_we,
  input  logic [RA_W-1:0] cpu_addr,
  input  logic [7:0]      cpu_data,
  input  logic            pend_vld,
  input  logic [15:0]     pend_word,
  output logic            take,
  output logic            wr_en,
  output logic [RA_W-1:0] wr_addr,
  output logic [7:0]      wr_data
);
  localparam int IDX_W = $clog2(NREG);

  logic [7:0] regs [NREG];

  dec_t            d;
  logic [7:0]      src_val;
  logic            w_en;
  logic [RA_W-1:0] w_addr;
  logic [7:0]      w_data;

  assign d    = decode(pend_word);
  // the CPU owns the write port in its cycle; the list word waits
  assign take = pend_vld && !cpu_we;

  always_comb begin
    if (int'(d.src) < NREG) src_val = regs[d.src[IDX_W-1:0]];
    else                    src_val = '0;
  end

  always_comb begin
    w_en   = 1'b0;
    w_addr = cpu_addr;
    w_data = cpu_data;
    if (cpu_we) begin
      w_en = (int'(cpu_addr) < NREG);
    end else if (pend_vld) begin
      w_addr = d.dst;
      w_data = d.is_ld ? d.imm : src_val;
      w_en   = (int'(d.dst) < NREG);
    end
  end

  always_ff @(posedge clk) begin
    if (w_en) regs[w_addr[IDX_W-1:0]] <= w_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= w_en;
      wr_addr <= w_addr;
      wr_data <= w_data;
    end
  end

  AST_CPU_FIRST: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && int'(cpu_addr) < NREG) |=>
      (wr_en && wr_addr == $past(cpu_addr) && wr_data == $past(cpu_data))); // R7
  AST_LD_IMM: assert property (@(posedge clk) disable iff (rst)
    (take && pend_word[15] && int'(pend_word[14:8]) < NREG) |=>
      (wr_en && wr_data == $past(pend_word[7:0])));                         // R3
  AST_MAPPED_ONLY: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < NREG));                                      // R9
endmodule

// File: rtl/dlist_copro.sv
`timescale 1ns/1ps
module dlist_copro
  import dlc_pkg::*;
#(
  parameter int AW       = 16,
  parameter int NREG     = 32,
  parameter int HW       = 10,
  parameter int VW       = 10,
  parameter int V_RELOAD = 480
) (
  input  logic          clk,
  input  logic          rst,
  output logic          dma_req,
  output logic [AW-1:0] dma_addr,
  input  logic          dma_gnt,
  input  logic [7:0]    dma_data,
  input  logic          cpu_ptr_we,
  input  logic [AW-1:0] cpu_ptr,
  input  logic          cpu_we,
  input  logic [6:0]    cpu_addr,
  input  logic [7:0]    cpu_data,
  input  logic [HW-1:0] h_pos,
  input  logic [VW-1:0] v_pos,
  output logic          reg_wr_en,
  output logic [6:0]    reg_wr_addr,
  output logic [7:0]    reg_wr_data
);
  logic        pend_vld;
  logic [15:0] pend_word;
  logic        take;

  dlc_fetch #(.AW(AW), .HW(HW), .VW(VW), .V_RELOAD(V_RELOAD)) u_fetch (
    .clk(clk), .rst(rst), .h_pos(h_pos), .v_pos(v_pos),
    .ptr_we(cpu_ptr_we), .ptr_in(cpu_ptr),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_gnt(dma_gnt), .dma_data(dma_data),
    .pend_vld(pend_vld), .pend_word(pend_word), .take(take)
  );

  dlc_exec #(.NREG(NREG)) u_exec (
    .clk(clk), .rst(rst),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .pend_vld(pend_vld), .pend_word(pend_word), .take(take),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!reg_wr_en && !dma_req));                               // R1
endmodule

// File: tb/dlist_copro_bench.sv
`timescale 1ns/1ps
module dlist_copro_bench;
  localparam int AW = 16, NREG = 32, HW = 10, VW = 10, VRL = 480;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, dma_req, dma_gnt, cpu_ptr_we, cpu_we, reg_wr_en;
  logic [AW-1:0] dma_addr, cpu_ptr;
  logic [7:0] dma_data, cpu_data, reg_wr_data;
  logic [6:0] cpu_addr, reg_wr_addr;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;

  logic [7:0] mem [256];
  assign dma_data = mem[dma_addr[7:0]];

  dlist_copro #(.AW(AW), .NREG(NREG), .HW(HW), .VW(VW), .V_RELOAD(VRL)) u_dlist_copro (
    .clk(clk), .rst(rst), .dma_req(dma_req), .dma_addr(dma_addr), .dma_gnt(dma_gnt),
    .dma_data(dma_data), .cpu_ptr_we(cpu_ptr_we), .cpu_ptr(cpu_ptr), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .h_pos(h_pos), .v_pos(v_pos),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
  );

  int n_chk = 0, n_err = 0, tick = 0;
  bit rand_gnt = 0;
  int ev_n = 0, ex_n = 0;
  int ev_t [64]; int ev_a [64]; int ev_d [64];
  int ex_t [64]; int ex_a [64]; int ex_d [64];
  int model [128];
  logic [15:0] prog [32];
  int prog_n;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    tick++;
    if (reg_wr_en && ev_n < 64) begin
      ev_t[ev_n] = tick; ev_a[ev_n] = int'(reg_wr_addr); ev_d[ev_n] = int'(reg_wr_data);
      ev_n++;
    end
    dma_gnt = rand_gnt ? 1'($urandom % 2) : 1'b1;
    cpu_we = 1'b0; cpu_ptr_we = 1'b0; h_pos = HW'(1);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic logic [15:0] enc_ld(input int dst, input int imm);
    return {1'b1, 7'(dst), 8'(imm)};
  endfunction
  function automatic logic [15:0] enc_cp(input int src, input int dst, input bit b14);
    return {1'b0, b14, 7'(src), 7'(dst)};
  endfunction

  task automatic expect_w(input int t, input int a, input int dv);
    if (a < NREG) begin
      ex_t[ex_n] = t; ex_a[ex_n] = a; ex_d[ex_n] = dv; ex_n++;
      model[a] = dv;
    end
  endtask

  task automatic load_prog(input int base);
    for (int i = 0; i < prog_n; i++) begin
      mem[base + 2*i]     = prog[i][7:0];
      mem[base + 2*i + 1] = prog[i][15:8];
    end
  endtask

  // expected writes from the encodings in R3, R4, R8, R9; times per R5
  task automatic run_model(input int r);
    for (int k = 0; k < prog_n; k++) begin
      logic [15:0] w; int dst; int v;
      w = prog[k];
      dst = w[15] ? int'(w[14:8]) : int'(w[6:0]);
      if (dst == 127) break;
      if (w[15]) v = int'(w[7:0]);
      else v = (int'(w[13:7]) < NREG) ? model[int'(w[13:7])] : 0;
      expect_w(r + 3 + 2*k, dst, v);
    end
  endtask

  task automatic compare(input string req, input bit timed);
    check(ev_n == ex_n, req, "write count", ev_n, ex_n);
    for (int i = 0; i < ev_n && i < ex_n; i++) begin
      check(ev_a[i] == ex_a[i], req, "write addr", ev_a[i], ex_a[i]);
      check(ev_d[i] == ex_d[i], req, "write data", ev_d[i], ex_d[i]);
      if (timed) check(ev_t[i] == ex_t[i], req, "write cycle", ev_t[i], ex_t[i]);
    end
    ev_n = 0; ex_n = 0;
  endtask

  task automatic set_ptr(input int p);
    step(); cpu_ptr_we = 1'b1; cpu_ptr = AW'(p);
  endtask

  // returns the tick number of the reload edge
  task automatic reload(output int r);
    h_pos = '0; r = tick + 1;
  endtask

  initial begin : watchdog
    #1_500_000;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", tick, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int r, r2;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 128; i++) model[i] = 0;
    rst = 1'b1; dma_gnt = 1'b1; cpu_we = 1'b0; cpu_ptr_we = 1'b0; cpu_ptr = '0;
    cpu_addr = '0; cpu_data = '0; h_pos = HW'(1); v_pos = VW'(VRL);
    steps(3);
    rst = 1'b0;
    steps(3);
    check(dma_req == 1'b0, "R1", "dma_req after reset", dma_req, 0);
    check(reg_wr_en == 1'b0, "R1", "reg_wr_en after reset", reg_wr_en, 0);
    ev_n = 0;

    // R7: CPU fills every mapped register; each shows next cycle
    for (int i = 0; i < NREG; i++) begin
      step(); cpu_we = 1'b1; cpu_addr = 7'(i); cpu_data = 8'(i*7 + 3);
      expect_w(tick + 1, i, (i*7 + 3) & 255);
    end
    steps(2);
    compare("R7", 1'b1);

    // Directed list: R2 R3 R4 R5 R8 R9 R11
    prog_n = 7;
    prog[0] = enc_ld(16, 8'h5A);
    prog[1] = enc_ld(8, 8'hC3);
    prog[2] = enc_cp(16, 31, 1'b0);
    prog[3] = enc_cp(8, 0, 1'b1);
    prog[4] = enc_ld(40, 8'h77);
    prog[5] = enc_cp(48, 1, 1'b0);
    prog[6] = enc_ld(127, 0);
    load_prog(16);
    set_ptr(16);
    step(); reload(r);
    step();
    check(dma_req == 1'b1 && dma_addr == AW'(16), "R2", "first fetch addr", int'(dma_addr), 16);
    step();
    check(dma_addr == AW'(17), "R11", "address step", int'(dma_addr), 17);
    steps(28);
    run_model(r);
    compare("R5", 1'b1);
    check(dma_req == 1'b0, "R8", "request after stop", dma_req, 0);

    // R7 collision: CPU write on the edge a list write would retire
    prog_n = 4;
    prog[0] = enc_ld(17, 8'h21);
    prog[1] = enc_ld(18, 8'h22);
    prog[2] = enc_ld(19, 8'h23);
    prog[3] = enc_ld(127, 0);
    load_prog(64);
    set_ptr(64);
    step(); reload(r);
    while (tick < r + 4) step();
    cpu_we = 1'b1; cpu_addr = 7'd5; cpu_data = 8'hEE;
    steps(12);
    expect_w(r + 3, 17, 8'h21);
    expect_w(r + 5, 5, 8'hEE);
    expect_w(r + 6, 18, 8'h22);
    expect_w(r + 8, 19, 8'h23);
    compare("R7", 1'b1);

    // R9: CPU write to an unmapped address is dropped
    step(); cpu_we = 1'b1; cpu_addr = 7'd80; cpu_data = 8'h99;
    step();
    check(reg_wr_en == 1'b0, "R9", "unmapped cpu write", reg_wr_en, 0);
    steps(2);
    check(ev_n == 0, "R9", "unmapped cpu write events", ev_n, 0);
    ev_n = 0;

    // R10: pointer change is deferred; reload mid-instruction discards it
    prog_n = 4;
    prog[0] = enc_ld(20, 8'h31);
    prog[1] = enc_ld(21, 8'h32);
    prog[2] = enc_ld(22, 8'h33);
    prog[3] = enc_ld(127, 0);
    load_prog(96);
    prog_n = 2;
    prog[0] = enc_ld(23, 8'h41);
    prog[1] = enc_ld(127, 0);
    load_prog(128);
    set_ptr(96);
    step(); reload(r);
    step();
    cpu_ptr_we = 1'b1; cpu_ptr = AW'(128);
    while (tick < r + 3) step();
    reload(r2);
    step();
    check(dma_addr == AW'(128), "R10", "restart addr", int'(dma_addr), 128);
    steps(12);
    expect_w(r + 3, 20, 8'h31);
    expect_w(r2 + 3, 23, 8'h41);
    compare("R10", 1'b1);

    // R6: random lists under random grant
    rand_gnt = 1'b1;
    for (int round = 0; round < 4; round++) begin
      prog_n = 13;
      for (int k = 0; k < 12; k++) begin
        int a, b;
        a = $urandom % 40; b = $urandom % 40;
        if ($urandom % 2) prog[k] = enc_ld(a, $urandom % 256);
        else prog[k] = enc_cp(b, a, 1'($urandom % 2));
      end
      prog[12] = enc_ld(127, 0);
      load_prog(160);
      set_ptr(160);
      step(); reload(r);
      steps(160);
      run_model(r);
      compare("R6", 1'b0);
      check(dma_req == 1'b0, "R8", "random list stopped", dma_req, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule